// File: doc/BRIEF.md
# Flash Row-Buffer Read Controller

This block connects a 32-bit instruction-fetch port to a flash array that is read one whole row at a time. It keeps a single row, 128 bytes by default, in a local row buffer, together with the index of that row and a valid flag. A fetch whose word lies in the buffered row is answered in the cycle in which it is presented. A fetch to any other row first spends one cycle loading that row from the array, and then completes as a hit. The cost is the same whether the new row follows the current one or is the target of a jump. A straight-line loop therefore pays one extra cycle at every row boundary it crosses and one more when it jumps back to its start.

The requester presents a word address and raises its request. It holds the address steady until ready goes high. The array returns the requested row within the same cycle that the row-read strobe is high, and the buffer captures it at the end of that cycle. An invalidate input empties the buffer. Two free-running counters report how many fetches were served straight from the buffer and how many row loads were needed.

Top module: `frb_ctrl`

## Requirements
- R1: When a request is present, the buffer is valid, and address bits [16:7] equal the buffered row index, ready is high in the same cycle. The read data is then the 32-bit word selected by address bits [6:2], where word k of a row occupies row bits [32k+31:32k].
- R2: A request to a row that is not buffered keeps ready low for one cycle. In that cycle the row-read strobe is high and the row index output equals address bits [16:7]. The row is captured at the end of that cycle, and the held fetch completes in the next cycle, for a total latency of two cycles.
- R3: Moving sequentially into the next row costs the same extra cycle as a jump. A loop of 344 sequential words spanning 1376 bytes from a row-aligned start needs 11 row loads per iteration: 10 boundary crossings plus the jump back.
- R4: After a synchronous active-low reset, the buffer is empty and both counters read zero. The first fetch after reset always takes two cycles, even to the row that was open before the reset.
- R5: While invalidate is high, ready and the row-read strobe stay low, no counter moves, and the buffer is left empty. Invalidate takes precedence over a request in the same cycle, and the next fetch to the old row takes two cycles.
- R6: The hit counter rises by one for each completed fetch that needed no row load. The miss counter rises by one for each row-load cycle. The two counters never rise on the same clock edge.
- R7: With no request and no invalidate, ready and the row-read strobe stay low and neither counter changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval_i | input | 1 | Empty the row buffer; overrides any request in the same cycle |
| req_i | input | 1 | Fetch request, held until ready |
| addr_i | input | 15 | Fetch word address, byte-address bits [16:2] |
| rdy_o | output | 1 | Fetch completes in this cycle |
| rdata_o | output | 32 | Fetched word, valid while rdy_o is high |
| arr_rd_o | output | 1 | Row-read strobe to the array |
| arr_row_o | output | 10 | Row index to read |
| arr_data_i | input | 1024 | Row contents returned by the array in the strobe cycle |
| hit_cnt_o | output | 32 | Fetches served from the buffer |
| miss_cnt_o | output | 32 | Row loads performed |

## Verification
Two functions can fall in the same cycle: an invalidate and a fetch that would otherwise hit the open row. The bench provokes this by raising invalidate together with a request into the row that was just used. In that cycle it expects ready and the row-read strobe to stay low. In the following cycle it expects a fill of the same row, then a completion with the correct word, and exactly one extra miss and no extra hit on the counters. Row crossings during sequential execution are judged by the total latency and the miss count of a two-iteration loop.

// File: rtl/frb_pkg.sv
// Package: shared types of the flash row-buffer read controller.
// Assumes nothing beyond its users importing it before use.
package frb_pkg;

    // Classification of one cycle at the fetch port.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,   // no request, no invalidate
        ACC_HIT   = 2'd1,   // request served from the open row
        ACC_FILL  = 2'd2,   // request needs a row load this cycle
        ACC_FLUSH = 2'd3    // invalidate, overrides any request
    } frb_acc_e;

endpackage

// File: rtl/frb_row_buf.sv
// Module: frb_row_buf
// Holds one flash row, its index and a valid flag, and selects one word of
// it for the read path. Assumes load_i and flush_i are never high together;
// the row contents carry no reset because the valid flag guards them.
module frb_row_buf #(
    parameter  int ROW_W     = 1024,
    parameter  int WORD_W    = 32,
    parameter  int ROW_IDX_W = 10,
    localparam int WORDS     = ROW_W / WORD_W,
    localparam int WSEL_W    = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 load_i,
    input  logic [ROW_IDX_W-1:0] load_row_i,
    input  logic [ROW_W-1:0]     load_data_i,
    input  logic [WSEL_W-1:0]    wsel_i,
    output logic                 valid_o,
    output logic [ROW_IDX_W-1:0] row_o,
    output logic [WORD_W-1:0]    word_o
);

    logic                 valid_q;
    logic [ROW_IDX_W-1:0] row_q;
    logic [ROW_W-1:0]     data_q;
    logic [WORD_W-1:0]    words [WORDS];

    // Valid flag: cleared by reset or flush, set by a row load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (flush_i) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
        end
    end

    // Row index register: records which row the buffer holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (load_i) begin
            row_q <= load_row_i;
        end
    end

    // Row contents: captured whole at the end of a load cycle.
    always_ff @(posedge clk) begin
        if (load_i) begin
            data_q <= load_data_i;
        end
    end

    // Split the row into words, word k at bits [k*WORD_W +: WORD_W].
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = data_q[g*WORD_W +: WORD_W];
    end

    // Word select for the read path.
    always_comb begin
        word_o = words[wsel_i];
    end

    assign valid_o = valid_q;
    assign row_o   = row_q;

endmodule

// File: rtl/frb_seq.sv
// Module: frb_seq
// Classifies each cycle as idle, hit, fill or flush and derives ready, the
// row-load strobe and the counter increments. Assumes the requester holds
// its address while ready is low, so a fill is followed by its completion.
module frb_seq
    import frb_pkg::*;
#(
    parameter int ROW_IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 inval_i,
    input  logic [ROW_IDX_W-1:0] row_req_i,
    input  logic                 buf_valid_i,
    input  logic [ROW_IDX_W-1:0] buf_row_i,
    output logic                 rdy_o,
    output logic                 fill_o,
    output logic                 flush_o,
    output logic                 cnt_hit_o,
    output logic                 cnt_miss_o
);

    frb_acc_e acc;
    logic     row_match;
    logic     fill_q;

    // Open-row comparison against the requested row index.
    always_comb begin
        row_match = buf_valid_i && (buf_row_i == row_req_i);
    end

    // Cycle classification; invalidate has the highest priority.
    always_comb begin
        if (inval_i) begin
            acc = ACC_FLUSH;
        end else if (!req_i) begin
            acc = ACC_IDLE;
        end else if (row_match) begin
            acc = ACC_HIT;
        end else begin
            acc = ACC_FILL;
        end
    end

    // Remembers that the previous cycle loaded a row for the held fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
        end else begin
            fill_q <= (acc == ACC_FILL);
        end
    end

    // Port-side controls and counter events.
    always_comb begin
        rdy_o      = (acc == ACC_HIT);
        fill_o     = (acc == ACC_FILL);
        flush_o    = (acc == ACC_FLUSH);
        cnt_hit_o  = (acc == ACC_HIT) && !fill_q;
        cnt_miss_o = (acc == ACC_FILL);
    end

endmodule

// File: rtl/frb_counter.sv
// Module: frb_counter
// Free-running event counter that wraps at its width.
// Assumes one event per cycle at most.
module frb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: cleared by reset, stepped by one per event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/frb_ctrl.sv
// Module: frb_ctrl (top)
// Row-buffer read controller between an instruction-fetch port and a flash
// array read one row at a time. Assumes the array returns the addressed row
// within the cycle that arr_rd_o is high, and that the requester holds
// addr_i until rdy_o rises.
module frb_ctrl #(
    parameter  int ADDR_W    = 17,
    parameter  int ROW_BYTES = 128,
    parameter  int WORD_W    = 32,
    parameter  int CNT_W     = 32,
    localparam int ROW_W     = ROW_BYTES * 8,
    localparam int WORDS     = ROW_W / WORD_W,
    localparam int WSEL_W    = $clog2(WORDS),
    localparam int BSEL_W    = $clog2(WORD_W / 8),
    localparam int ROW_LSB   = BSEL_W + WSEL_W,
    localparam int ROW_IDX_W = ADDR_W - ROW_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inval_i,
    input  logic                 req_i,
    input  logic [ADDR_W-1:BSEL_W] addr_i,
    output logic                 rdy_o,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 arr_rd_o,
    output logic [ROW_IDX_W-1:0] arr_row_o,
    input  logic [ROW_W-1:0]     arr_data_i,
    output logic [CNT_W-1:0]     hit_cnt_o,
    output logic [CNT_W-1:0]     miss_cnt_o
);

    logic [ROW_IDX_W-1:0] row_req;
    logic [WSEL_W-1:0]    wsel;
    logic                 buf_valid;
    logic [ROW_IDX_W-1:0] buf_row;
    logic                 fill;
    logic                 flush;
    logic                 cnt_hit;
    logic                 cnt_miss;

    // Address split into row index and word select.
    always_comb begin
        row_req = addr_i[ADDR_W-1:ROW_LSB];
        wsel    = addr_i[ROW_LSB-1:BSEL_W];
    end

    frb_row_buf #(
        .ROW_W     (ROW_W),
        .WORD_W    (WORD_W),
        .ROW_IDX_W (ROW_IDX_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .load_i      (fill),
        .load_row_i  (row_req),
        .load_data_i (arr_data_i),
        .wsel_i      (wsel),
        .valid_o     (buf_valid),
        .row_o       (buf_row),
        .word_o      (rdata_o)
    );

    frb_seq #(
        .ROW_IDX_W (ROW_IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .inval_i     (inval_i),
        .row_req_i   (row_req),
        .buf_valid_i (buf_valid),
        .buf_row_i   (buf_row),
        .rdy_o       (rdy_o),
        .fill_o      (fill),
        .flush_o     (flush),
        .cnt_hit_o   (cnt_hit),
        .cnt_miss_o  (cnt_miss)
    );

    frb_counter #(.CNT_W(CNT_W)) u_hit_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (cnt_hit),
        .cnt_o (hit_cnt_o)
    );

    frb_counter #(.CNT_W(CNT_W)) u_miss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (cnt_miss),
        .cnt_o (miss_cnt_o)
    );

    // Array read port driven straight from the fill decision.
    assign arr_rd_o  = fill;
    assign arr_row_o = row_req;

endmodule

// File: rtl/frb_ctrl_chk.sv
// Module: frb_ctrl_chk
// Protocol checker for frb_ctrl, attached by the bind at the end of this
// file. Observes ports only.
module frb_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int BSEL_W = 2,
    parameter int CNT_W  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inval_i,
    input logic                   req_i,
    input logic [ADDR_W-1:BSEL_W] addr_i,
    input logic                   rdy_o,
    input logic                   arr_rd_o,
    input logic [CNT_W-1:0]       hit_cnt_o,
    input logic [CNT_W-1:0]       miss_cnt_o
);

    // R2: a load cycle is followed by completion of the same held fetch.
    assert_fill_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_o && !inval_i) |=> (rdy_o || !req_i || inval_i || !$stable(addr_i)));

    // R2: ready and the row-read strobe are never high together.
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_o && arr_rd_o));

    // R4: reset clears both counters and leaves the buffer empty.
    assert_reset_clears_R4: assert property (@(posedge clk)
        !rst_n |=> (hit_cnt_o == '0 && miss_cnt_o == '0 && !rdy_o));

    // R5: an invalidate cycle completes nothing and reads nothing.
    assert_flush_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inval_i |-> (!rdy_o && !arr_rd_o));

    // R5: the buffer is empty in the cycle after an invalidate.
    assert_empty_after_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inval_i |=> !rdy_o);

    // R6: every load cycle adds exactly one to the miss counter.
    assert_fill_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_o |=> (miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1)));

    // R6: the two counters never step on the same edge.
    assert_single_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hit_cnt_o == $past(hit_cnt_o) || miss_cnt_o == $past(miss_cnt_o)));

    // R7: an idle cycle completes nothing and leaves the counters still.
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !inval_i) |-> (!rdy_o && !arr_rd_o));

    assert_idle_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !inval_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o)));

endmodule

bind frb_ctrl frb_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .BSEL_W (BSEL_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inval_i    (inval_i),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .rdy_o      (rdy_o),
    .arr_rd_o   (arr_rd_o),
    .hit_cnt_o  (hit_cnt_o),
    .miss_cnt_o (miss_cnt_o)
);

// File: tb/frb_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for frb_ctrl: behavioural flash array, a vector table of fetches
// with expected latency, then directed tests for invalidate, looping,
// reset and idle.
module frb_ctrl_bench;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          inval;
    logic          req;
    logic [16:2]   addr;
    logic          rdy;
    logic [31:0]   rdata;
    logic          arr_rd;
    logic [9:0]    arr_row;
    logic [1023:0] arr_data;
    logic [31:0]   hit_cnt;
    logic [31:0]   miss_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_hit  = 0;
    int exp_miss = 0;

    always #2.5 clk = ~clk;

    frb_ctrl u_frb_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval_i    (inval),
        .req_i      (req),
        .addr_i     (addr),
        .rdy_o      (rdy),
        .rdata_o    (rdata),
        .arr_rd_o   (arr_rd),
        .arr_row_o  (arr_row),
        .arr_data_i (arr_data),
        .hit_cnt_o  (hit_cnt),
        .miss_cnt_o (miss_cnt)
    );

    // Contents of word w of row r in the modelled array.
    function automatic logic [31:0] mem_word(input logic [9:0] r, input logic [4:0] w);
        logic [31:0] k;
        k = {17'd0, r, w};
        return (k * 32'h9E37_79B1) ^ 32'h3C5A_0F00;
    endfunction

    // Behavioural array: row returned within the strobe cycle.
    always_comb begin
        for (int w = 0; w < 32; w++) begin
            arr_data[w*32 +: 32] = mem_word(arr_row, w[4:0]);
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Present one fetch at a falling edge, wait for ready, return latency.
    task automatic raw_fetch(input logic [16:0] a, output int lat, output logic [31:0] d);
        lat  = 1;
        req  = 1'b1;
        addr = a[16:2];
        #1;
        while (!rdy && lat < 8) begin
            @(negedge clk);
            #1;
            lat++;
        end
        d = rdata;
        @(negedge clk);
    endtask

    task automatic do_fetch(input logic [16:0] a, input int exp_lat, input string rq);
        int          lat;
        logic [31:0] d;
        raw_fetch(a, lat, d);
        check(lat == exp_lat, rq, "latency", lat, exp_lat);
        check(d == mem_word(a[16:7], a[6:2]), "R1", "data", d, mem_word(a[16:7], a[6:2]));
        if (exp_lat == 1) exp_hit++; else exp_miss++;
    endtask

    task automatic check_counts(input string rq);
        check(hit_cnt == 32'(exp_hit), rq, "hit count", hit_cnt, exp_hit);
        check(miss_cnt == 32'(exp_miss), rq, "miss count", miss_cnt, exp_miss);
    endtask

    // Vectors: {byte address[16:0], expected latency[6:0]}.
    localparam logic [23:0] VEC [10] = '{
        {17'h00000, 7'd2},   // first fetch after reset: empty buffer
        {17'h00004, 7'd1},   // same row
        {17'h0007C, 7'd1},   // last word of row 0
        {17'h00080, 7'd2},   // sequential crossing into row 1
        {17'h00084, 7'd1},
        {17'h1F000, 7'd2},   // jump far
        {17'h1FFFC, 7'd2},   // last row, last word
        {17'h1FF80, 7'd1},   // first word of last row
        {17'h00000, 7'd2},   // jump back to row 0
        {17'h00000, 7'd1}    // repeat same word
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int          lat;
        int          tot;
        int          miss0;
        logic [31:0] d;

        rst_n = 1'b0;
        inval = 1'b0;
        req   = 1'b0;
        addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R4: reset state
        check(!rdy && !arr_rd, "R4", "ready/strobe after reset", {rdy, arr_rd}, 0);
        check_counts("R4");
        @(negedge clk);

        // R1 R2 R3: table of fetches
        for (int i = 0; i < 10; i++) begin
            do_fetch(VEC[i][23:7], int'(VEC[i][6:0]), (VEC[i][6:0] == 7'd1) ? "R1" : "R2");
        end
        check_counts("R6");

        // R2: observe the fill cycle directly
        req  = 1'b1;
        addr = 15'h0100 >> 0;   // byte 0x400, row 8 word 0
        #1;
        check(arr_rd && !rdy, "R2", "fill strobe", {arr_rd, rdy}, 2'b10);
        check(arr_row == 10'd8, "R2", "fill row", arr_row, 8);
        @(negedge clk);
        #1;
        check(rdy && rdata == mem_word(10'd8, 5'd0), "R2", "fill completion", rdata, mem_word(10'd8, 5'd0));
        exp_miss++;
        @(negedge clk);

        // R5: invalidate together with a would-be hit
        do_fetch(17'h00404, 1, "R1");
        req   = 1'b1;
        addr  = 17'h00408 >> 2;
        inval = 1'b1;
        #1;
        check(!rdy && !arr_rd, "R5", "invalidate cycle quiet", {rdy, arr_rd}, 0);
        @(negedge clk);
        inval = 1'b0;
        #1;
        check(arr_rd && !rdy && arr_row == 10'd8, "R5", "refill after invalidate", {arr_rd, rdy}, 2'b10);
        @(negedge clk);
        #1;
        check(rdy && rdata == mem_word(10'd8, 5'd2), "R5", "completion after refill", rdata, mem_word(10'd8, 5'd2));
        exp_miss++;
        @(negedge clk);
        check_counts("R5");

        // R5: invalidate while idle, then same row misses
        req   = 1'b0;
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        do_fetch(17'h0040C, 2, "R5");

        // R3: two iterations of a 1376-byte straight-line loop
        tot   = 0;
        miss0 = int'(miss_cnt);
        for (int it = 0; it < 2; it++) begin
            for (int i = 0; i < 344; i++) begin
                raw_fetch(17'h00300 + 17'(i * 4), lat, d);
                tot += lat;
            end
        end
        check(tot == 710, "R3", "loop cycles", tot, 710);
        check(int'(miss_cnt) - miss0 == 22, "R3", "loop row loads", int'(miss_cnt) - miss0, 22);
        exp_miss += 22;
        exp_hit  += 688 - 22;
        check_counts("R6");

        // R4: reset mid-run empties the buffer and the counters
        req   = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        exp_hit  = 0;
        exp_miss = 0;
        check_counts("R4");
        @(negedge clk);
        do_fetch(17'h0085C, 2, "R4");

        // R7: idle cycles change nothing
        req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!rdy && !arr_rd, "R7", "idle outputs", {rdy, arr_rd}, 0);
            @(negedge clk);
        end
        check_counts("R7");

        summary();
    end

endmodule